// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs the fixed state-saving routine a processor core goes through once it has decided to take an exception. A one-cycle accept strobe hands it four things: the vector number, the live status word, the address of the next instruction and the supervisor stack pointer. It also receives a flag that says whether this entry is itself an address-error or reset entry. The block keeps an unmodified copy of the status word. It then drives the new status, with supervisor mode set and tracing switched off. It pushes three 16-bit words onto the supervisor stack through a plain word-wide memory port. Finally it fetches the 32-bit handler address from the vector table and hands it to instruction fetch with a one-cycle done pulse.

The block checks every access it issues for alignment. An odd stack pointer or an odd vector base in an ordinary entry suppresses the access, aborts the routine and reports a fault, so the core can start an address-error entry. The same fault inside an address-error or reset entry parks the block in a halted state, which only reset clears.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, fault_o, halt_o, mem_we_o and mem_re_o are low, and sr_o equals 16'h2700.
- R2: The status word written to the stack equals sr_i as sampled with the accept strobe, before any bit of it is changed.
- R3: From the first cycle after an accepted strobe, sr_o equals the sampled status with bit 13 (supervisor) set and bit 15 (trace) cleared, and all other bits unchanged.
- R4: An accepted entry writes in the 1st, 2nd and 3rd cycles after the strobe: pc_i[15:0] at sp_i-2, pc_i[31:16] at sp_i-4, and the status copy at sp_i-6. Once these are done, sp_o equals sp_i-6.
- R5: In the 4th and 5th cycles the block reads the handler address at vbase_i+4*vec_i (high half) and vbase_i+4*vec_i+2 (low half), read data being valid in the cycle the read is issued.
- R6: done_o is high for exactly the 6th cycle after the strobe, with new_pc_o equal to {high half, low half}. busy_o is low in that cycle.
- R7: An accept strobe while busy_o is high is ignored: the running sequence's addresses, data and single done pulse are unchanged.
- R8: In an entry with aerr_entry_i low, an access to an odd address is not issued. Instead, fault_o pulses for one cycle in the following cycle, the block returns to idle with no done pulse, and halt_o stays low.
- R9: In an entry with aerr_entry_i high, an access to an odd address is not issued. Instead, halt_o rises in the following cycle and stays high until reset, with no done pulse, no fault pulse, and no further accesses even on a new strobe.
- R10: mem_we_o and mem_re_o are never asserted with an odd mem_addr_o, and never together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | One-cycle strobe: exception accepted |
| aerr_entry_i | input | 1 | Entry being accepted is an address-error or reset entry |
| vec_i | input | 8 | Vector number |
| sr_i | input | 16 | Status word before entry |
| pc_i | input | 32 | Next-instruction address to be stacked |
| sp_i | input | 32 | Supervisor stack pointer before entry |
| vbase_i | input | 32 | Vector table base address |
| sr_o | output | 16 | Status word in force after entry |
| sp_o | output | 32 | Working stack pointer |
| mem_we_o | output | 1 | Memory word write strobe |
| mem_re_o | output | 1 | Memory word read strobe |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid in the cycle of mem_re_o |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: handler address ready |
| new_pc_o | output | 32 | Handler address |
| fault_o | output | 1 | One-cycle pulse: misaligned access in an ordinary entry |
| halt_o | output | 1 | Core halted by a fault inside an address-error entry |

## Verification
The hardest case to reach is a misaligned access that appears only after stacking has finished. This is the fault at the vector fetch, inside an address-error entry, which must halt the core after three valid writes and before any read. Since 4*vec_i is always even, the only way to reach this case is an even stack pointer paired with an odd vector base. The bench does exactly that with aerr_entry_i both high and low, then fires a new strobe into the halted block. It also injects a second strobe with a different stack pointer two cycles into a running entry, to show the first sequence is left untouched.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PC_LO, ST_PC_HI, ST_SR, ST_VEC_HI, ST_VEC_LO, ST_HALT
  } seq_st_e;
endpackage

// File: rtl/exc_sr_unit.sv
module exc_sr_unit #(
  parameter int SRW = 16,
  parameter int S_BIT = 13,
  parameter int T_BIT = 15,
  parameter logic [SRW-1:0] SR_RST = 16'h2700
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [SRW-1:0] sr_i,
  output logic [SRW-1:0] sr_o,
  output logic [SRW-1:0] saved_o
);
  logic [SRW-1:0] sr_mod;

  always_comb begin
    sr_mod        = sr_i;
    sr_mod[S_BIT] = 1'b1;
    sr_mod[T_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_o    <= SR_RST;
      saved_o <= '0;
    end else if (load_i) begin
      saved_o <= sr_i;   // copy taken from the unmodified input
      sr_o    <= sr_mod;
    end
  end

  // R3
  sr_entry_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sr_o[S_BIT] && !sr_o[T_BIT] && saved_o == $past(sr_i)));
endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen
  import exc_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 8,
  parameter int DW = 16
) (
  input  seq_st_e         st_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [AW-1:0]   vbase_i,
  input  logic [VW-1:0]   vec_i,
  output logic [AW-1:0]   addr_o,
  output logic            wr_o,
  output logic            rd_o,
  output logic            odd_o
);
  localparam int WB = DW / 8;
  localparam int ENTRY_B = 2 * WB;

  logic [AW-1:0] vec_addr;
  assign vec_addr = vbase_i + AW'(vec_i) * AW'(ENTRY_B);

  always_comb begin
    addr_o = '0;
    wr_o   = 1'b0;
    rd_o   = 1'b0;
    unique case (st_i)
      ST_PC_LO, ST_PC_HI, ST_SR: begin
        addr_o = sp_i - AW'(WB);
        wr_o   = 1'b1;
      end
      ST_VEC_HI: begin
        addr_o = vec_addr;
        rd_o   = 1'b1;
      end
      ST_VEC_LO: begin
        addr_o = vec_addr + AW'(WB);
        rd_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign odd_o = (wr_o | rd_o) & addr_o[0];
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int VW = 8,
  parameter int S_BIT = 13,
  parameter int T_BIT = 15,
  parameter logic [DW-1:0] SR_RST = 16'h2700
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              aerr_entry_i,
  input  logic [VW-1:0]     vec_i,
  input  logic [DW-1:0]     sr_i,
  input  logic [2*DW-1:0]   pc_i,
  input  logic [AW-1:0]     sp_i,
  input  logic [AW-1:0]     vbase_i,
  output logic [DW-1:0]     sr_o,
  output logic [AW-1:0]     sp_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2*DW-1:0]   new_pc_o,
  output logic              fault_o,
  output logic              halt_o
);
  localparam int PCW = 2 * DW;

  seq_st_e        st_q, st_d;
  logic [PCW-1:0] pc_q;
  logic [AW-1:0]  sp_q, vbase_q;
  logic [VW-1:0]  vec_q;
  logic           crit_q;
  logic [DW-1:0]  hi_q, saved_sr;
  logic           start, acc_wr, acc_rd, acc_odd;

  assign start = accept_i && (st_q == ST_IDLE);

  exc_sr_unit #(.SRW(DW), .S_BIT(S_BIT), .T_BIT(T_BIT), .SR_RST(SR_RST)) u_sr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .sr_i    (sr_i),
    .sr_o    (sr_o),
    .saved_o (saved_sr)
  );

  exc_addr_gen #(.AW(AW), .VW(VW), .DW(DW)) u_agen (
    .st_i    (st_q),
    .sp_i    (sp_q),
    .vbase_i (vbase_q),
    .vec_i   (vec_q),
    .addr_o  (mem_addr_o),
    .wr_o    (acc_wr),
    .rd_o    (acc_rd),
    .odd_o   (acc_odd)
  );

  // misaligned accesses never reach the bus
  assign mem_we_o = acc_wr & ~acc_odd;
  assign mem_re_o = acc_rd & ~acc_odd;

  always_comb begin
    unique case (st_q)
      ST_PC_HI: mem_wdata_o = pc_q[PCW-1:DW];
      ST_SR:    mem_wdata_o = saved_sr;
      default:  mem_wdata_o = pc_q[DW-1:0];
    endcase
  end

  always_comb begin
    st_d = st_q;
    if (acc_odd) begin
      st_d = crit_q ? ST_HALT : ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:   if (accept_i) st_d = ST_PC_LO;
        ST_PC_LO:  st_d = ST_PC_HI;
        ST_PC_HI:  st_d = ST_SR;
        ST_SR:     st_d = ST_VEC_HI;
        ST_VEC_HI: st_d = ST_VEC_LO;
        ST_VEC_LO: st_d = ST_IDLE;
        default:   st_d = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pc_q     <= '0;
      sp_q     <= '0;
      vbase_q  <= '0;
      vec_q    <= '0;
      crit_q   <= 1'b0;
      hi_q     <= '0;
      new_pc_o <= '0;
      done_o   <= 1'b0;
      fault_o  <= 1'b0;
    end else begin
      st_q    <= st_d;
      done_o  <= 1'b0;
      fault_o <= acc_odd & ~crit_q;
      if (start) begin
        pc_q    <= pc_i;
        sp_q    <= sp_i;
        vbase_q <= vbase_i;
        vec_q   <= vec_i;
        crit_q  <= aerr_entry_i;
      end
      if (mem_we_o) sp_q <= mem_addr_o;
      if (mem_re_o && st_q == ST_VEC_HI) hi_q <= mem_rdata_i;
      if (mem_re_o && st_q == ST_VEC_LO) begin
        new_pc_o <= {hi_q, mem_rdata_i};
        done_o   <= 1'b1;
      end
    end
  end

  assign sp_o   = sp_q;
  assign busy_o = (st_q != ST_IDLE) && (st_q != ST_HALT);
  assign halt_o = (st_q == ST_HALT);

  // R10
  no_odd_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> (!mem_addr_o[0] && !(mem_we_o && mem_re_o)));
  // R9
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && !mem_we_o && !mem_re_o && !done_o));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  sp_follows_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_o == $past(mem_addr_o));
  // R8
  fault_no_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!halt_o && !busy_o));
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept = 1'b0, aerr = 1'b0;
  logic [7:0]  vec = '0;
  logic [15:0] sr = '0;
  logic [31:0] pc = '0, sp = '0, vbase = '0;
  logic [15:0] sr_o, wdata, rdata;
  logic [31:0] sp_o, addr, new_pc;
  logic        we, re, busy, done, fault, halt;

  int total = 0, bad = 0;
  int nw, nr, done_n, done_k, fault_n, halt_k, odd_n;
  logic [31:0] wa[8], ra[8];
  logic [15:0] wd[8];
  int wk[8], rk[8];
  logic [31:0] done_pc;

  always #10 clk = ~clk;  // 50 MHz

  assign rdata = addr[15:0] ^ 16'h5AC3;

  exc_entry_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .accept_i(accept), .aerr_entry_i(aerr),
    .vec_i(vec), .sr_i(sr), .pc_i(pc), .sp_i(sp), .vbase_i(vbase),
    .sr_o(sr_o), .sp_o(sp_o), .mem_we_o(we), .mem_re_o(re),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .new_pc_o(new_pc), .fault_o(fault),
    .halt_o(halt)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    accept = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] rd_model(input logic [31:0] a);
    return a[15:0] ^ 16'h5AC3;
  endfunction

  // strobe once, then log ports at negedges k=1..10 after the sampling edge
  task automatic run(input logic [15:0] s, input logic [31:0] p, input logic [31:0] spv,
                     input logic [31:0] vb, input logic [7:0] v, input logic crit,
                     input bit inject);
    nw = 0; nr = 0; done_n = 0; done_k = 0; fault_n = 0; halt_k = 0; odd_n = 0;
    sr = s; pc = p; sp = spv; vbase = vb; vec = v; aerr = crit;
    accept = 1'b1;
    @(posedge clk);
    #1 accept = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if ((we || re) && addr[0]) odd_n++;
      if (we && nw < 8) begin wa[nw] = addr; wd[nw] = wdata; wk[nw] = k; nw++; end
      if (re && nr < 8) begin ra[nr] = addr; rk[nr] = k; nr++; end
      if (done) begin done_n++; done_k = k; done_pc = new_pc;
        chk("R6", "busy during done", {31'b0, busy}, 32'd0); end
      if (fault) fault_n++;
      if (halt && halt_k == 0) halt_k = k;
      if (inject && k == 2) begin
        sr = 16'hFFFF; pc = 32'h0BAD_0BAD; sp = 32'h0000_8000; vbase = 32'h100; accept = 1'b1;
      end
      if (inject && k == 3) accept = 1'b0;
    end
    sr = s; pc = p; sp = spv; vbase = vb; vec = v;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "busy", {31'b0, busy}, 32'd0);
    chk("R1", "done", {31'b0, done}, 32'd0);
    chk("R1", "fault", {31'b0, fault}, 32'd0);
    chk("R1", "halt", {31'b0, halt}, 32'd0);
    chk("R1", "we|re", {31'b0, we | re}, 32'd0);
    chk("R1", "sr_o", {16'b0, sr_o}, 32'h2700);
  endtask

  task automatic t_normal(input logic [15:0] s, input logic [31:0] p, input logic [31:0] spv,
                          input logic [31:0] vb, input logic [7:0] v, input bit inject);
    logic [31:0] va;
    logic [15:0] exp_sr;
    va = vb + 32'(v) * 4;
    exp_sr = (s | 16'h2000) & 16'h7FFF;
    run(s, p, spv, vb, v, 1'b0, inject);
    chk(inject ? "R7" : "R4", "write count", nw, 3);
    chk("R4", "pc lo addr", wa[0], spv - 2);
    chk("R4", "pc lo data", {16'b0, wd[0]}, {16'b0, p[15:0]});
    chk("R4", "pc hi addr", wa[1], spv - 4);
    chk("R4", "pc hi data", {16'b0, wd[1]}, {16'b0, p[31:16]});
    chk("R4", "sr addr", wa[2], spv - 6);
    chk("R2", "stacked status", {16'b0, wd[2]}, {16'b0, s});
    chk("R4", "write cycles", {wk[0][7:0], wk[1][7:0], wk[2][7:0], 8'h0}, 32'h0102_0300);
    chk("R4", "sp_o final", sp_o, spv - 6);
    chk("R3", "sr_o", {16'b0, sr_o}, {16'b0, exp_sr});
    chk("R5", "read count", nr, 2);
    chk("R5", "vec hi addr", ra[0], va);
    chk("R5", "vec lo addr", ra[1], va + 2);
    chk("R5", "read cycles", {rk[0][15:0], rk[1][15:0]}, 32'h0004_0005);
    chk(inject ? "R7" : "R6", "done count", done_n, 1);
    chk("R6", "done cycle", done_k, 6);
    chk("R5", "new pc", done_pc, {rd_model(va), rd_model(va + 2)});
    chk("R6", "idle after", {31'b0, busy}, 32'd0);
    chk("R10", "odd accesses", odd_n, 0);
  endtask

  task automatic t_bad_addr(input logic [31:0] spv, input logic [31:0] vb, input bit crit,
                            input int exp_nw, input int exp_k);
    run(16'h8004, 32'h0000_2468, spv, vb, 8'd3, crit, 1'b0);
    if (crit) begin
      chk("R9", "writes before halt", nw, exp_nw);
      chk("R9", "reads", nr, 0);
      chk("R9", "halt cycle", halt_k, exp_k);
      chk("R9", "halt held", {31'b0, halt}, 32'd1);
      chk("R9", "no fault/done", fault_n + done_n, 0);
      run(16'h0000, 32'h1000, 32'h2000, 32'h0, 8'd1, 1'b0, 1'b0);
      chk("R9", "strobe while halted", nw + nr + done_n, 0);
      chk("R9", "still halted", {31'b0, halt}, 32'd1);
      t_reset();
    end else begin
      chk("R8", "writes", nw, exp_nw);
      chk("R8", "reads", nr, 0);
      chk("R8", "fault pulses", fault_n, 1);
      chk("R8", "done", done_n, 0);
      chk("R8", "halt", halt_k, 0);
      chk("R8", "idle after", {31'b0, busy}, 32'd0);
    end
    chk("R10", "odd accesses", odd_n, 0);
  endtask

  initial begin
    #4ms;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_normal(16'hA71F, 32'h0012_3456, 32'h0000_4000, 32'h0000_0000, 8'd9, 1'b0);
    t_normal(16'h0000, 32'hFEDC_BA98, 32'h0001_0006, 32'h0000_0400, 8'd255, 1'b0);
    t_normal(16'h2304, 32'h0000_0C0A, 32'h0000_3002, 32'h0000_0800, 8'd32, 1'b1);
    t_bad_addr(32'h0000_4001, 32'h0000_0000, 1'b0, 0, 0);
    t_bad_addr(32'h0000_4000, 32'h0000_0101, 1'b0, 3, 0);
    t_normal(16'h8000, 32'h0000_0002, 32'h0000_5000, 32'h0000_0000, 8'd2, 1'b0);
    t_bad_addr(32'h0000_4000, 32'h0000_0201, 1'b1, 3, 5);
    t_bad_addr(32'h0000_4003, 32'h0000_0000, 1'b1, 0, 2);
    t_normal(16'h7FFF, 32'h1111_2222, 32'h0000_6000, 32'h0000_0000, 8'd4, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule